// File: doc/BRIEF.md
# Seeded Pseudo-Random Word Generator Peripheral

This block is a register-mapped generator of pseudo-random words that sits on a simple 32-bit register bus. Each access takes one cycle. A write is taken at the clock edge. A read returns data combinationally for the address presented. Software first loads five 32-bit seed words. It then writes the control register with the engine-select bit and the go bit both set. It polls the status register until the done flag appears, and then reads five fresh 32-bit result words.

The generator is deterministic so that it can be synthesized. When a start is accepted, a 160-bit xorshift state is copied from the five seed words. The state then advances once per clock for five clocks, and each advance produces one result word. Two groups of status bits behave differently. The three completion bits can be written directly by software. The remaining status bits are driven only by hardware.

Top module: `seeded_prng_periph`

## Requirements
- R1: After reset, control reads 0x0, status reads 0x01 (only bit 0, buffer ready, is set) and all five result words read 0.
- R2: Addresses are byte offsets: control 0x000, status 0x010, seeds k=0..4 at 0x140+4k, results k=0..4 at 0x160+4k. Every other offset reads 0, and this includes the seed offsets and unaligned offsets. Writes to result offsets or to unmapped offsets change nothing that can be read.
- R3: Each seed offset has its own written flag, and only reset clears these flags. Status bit 1 (seeds complete) reads 1 exactly when all five flags are set. Rewriting a seed that was already written does not set the bit on its own.
- R4: A control write stores all 32 written bits except bit 4, the go bit, which always reads back as 0.
- R5: A control write starts a run only if status bit 1 is set, written bit 3 (engine select) is 1, written bit 4 (go) is 1, and no run is in progress. Otherwise no run starts.
- R6: On an accepted start, state words s0..s4 are loaded from seeds 0..4. Each of the next five cycles performs one step: t = s0 ^ (s0 >> 2); s0..s3 take s1..s4; the new s4 = (s4 ^ (s4 << 4)) ^ (t ^ (t << 1)). Result word k receives the new s4 of step k+1. Status bit 2 (busy) reads 1 for exactly these five cycles.
- R7: Status bit 5 (done) becomes 1 in the same cycle that busy returns to 0.
- R8: A status write sets bits 5, 4 and 3 to the written values. Bit 0 stays 1, bits 1, 2 and 6 keep their hardware values, and bit 7 (error) reads 0.
- R9: If a status write lands on the edge where a run finishes, bit 5 reads 1 afterwards, while bits 4 and 3 take the written values.
- R10: A control write during a run is stored, with bit 4 cleared. Its start request is ignored, and the current run continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 9 | Byte offset within the 0x200 window |
| busWe | input | 1 | Write enable, sampled at the clock edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |

## Verification
Two events can fall on the same edge: the hardware setting done at the end of a run, and a software write to the status register. The bench provokes this by issuing a status write of zero exactly five cycles after an accepted start. A correct design shows bit 5 set and bits 4 and 3 cleared. A second overlap is a new start request that arrives while a run is still in progress. It must be stored but not restart the sequence. The bench judges this by checking that the result words match those of the unbroken run.

// File: rtl/prng_pkg.sv
package prng_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 5;
  localparam int ADDR_W    = 9;

  localparam logic [ADDR_W-1:0] CTRL_OFS  = 9'h000;
  localparam logic [ADDR_W-1:0] STAT_OFS  = 9'h010;
  localparam logic [ADDR_W-1:0] SEED_BASE = 9'h140;
  localparam logic [ADDR_W-1:0] OUT_BASE  = 9'h160;

  localparam int CTRL_ENG_BIT = 3;
  localparam int CTRL_GO_BIT  = 4;

  localparam int ST_ERR  = 7;
  localparam int ST_DONE = 5;
  localparam int ST_MSG  = 4;
  localparam int ST_PART = 3;
  localparam int ST_BUSY = 2;
  localparam int ST_SEED = 1;
  localparam int ST_RDY  = 0;

  typedef struct packed {
    logic       load;
    logic       step;
    logic [2:0] wordSel;
    logic       seedWe;
    logic [2:0] seedSel;
  } prng_cmd_t;
endpackage

// File: rtl/prng_ctrl.sv
module prng_ctrl
  import prng_pkg::*;
#(
  parameter int NW = NUM_WORDS,
  parameter int DW = WORD_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] busAddr,
  input  logic          busWe,
  input  logic [DW-1:0] busWdata,
  output prng_cmd_t     cmd,
  output logic [DW-1:0] ctrlValue,
  output logic [DW-1:0] statusValue,
  output logic          busy,
  output logic          ctrlHit,
  output logic          statHit
);
  localparam int CNT_W = $clog2(NW + 1);
  localparam logic [AW-1:0] SEED_SPAN = AW'(4 * NW);

  logic [CNT_W-1:0] stepsLeft;
  logic [NW-1:0]    seedFlags;
  logic [AW-1:0]    seedOfs;
  logic             seedHit, seedDone, goReq, lastStep;
  logic             doneFlag, msgFlag, partFlag, rdyFlag;

  assign ctrlHit  = (busAddr == CTRL_OFS);
  assign statHit  = (busAddr == STAT_OFS);
  assign seedOfs  = busAddr - SEED_BASE;
  assign seedHit  = (seedOfs < SEED_SPAN) && (seedOfs[1:0] == 2'b00);
  assign seedDone = &seedFlags;
  assign busy     = (stepsLeft != '0);
  assign lastStep = (stepsLeft == CNT_W'(1));
  assign goReq    = busWe && ctrlHit && busWdata[CTRL_ENG_BIT]
                    && busWdata[CTRL_GO_BIT] && seedDone && !busy;

  always_comb begin
    cmd         = '0;
    cmd.load    = goReq;
    cmd.step    = busy;
    cmd.wordSel = 3'(NW - int'(stepsLeft));
    cmd.seedWe  = busWe && seedHit;
    cmd.seedSel = seedOfs[2 +: 3];
  end

  for (genvar g = 0; g < NW; g++) begin : gSeedFlag
    always_ff @(posedge clk) begin
      if (!rstN) seedFlags[g] <= 1'b0;
      else if (cmd.seedWe && cmd.seedSel == 3'(g)) seedFlags[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepsLeft <= '0;
    end else if (goReq) begin
      stepsLeft <= CNT_W'(NW);
    end else if (busy) begin
      stepsLeft <= stepsLeft - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlValue <= '0;
    end else if (busWe && ctrlHit) begin
      ctrlValue <= busWdata & ~(DW'(1) << CTRL_GO_BIT);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneFlag <= 1'b0;
      msgFlag  <= 1'b0;
      partFlag <= 1'b0;
      rdyFlag  <= 1'b1;
    end else begin
      if (busWe && statHit) begin
        doneFlag <= busWdata[ST_DONE];
        msgFlag  <= busWdata[ST_MSG];
        partFlag <= busWdata[ST_PART];
      end
      if (busy && lastStep) doneFlag <= 1'b1;
    end
  end

  always_comb begin
    statusValue          = '0;
    statusValue[ST_ERR]  = 1'b0;
    statusValue[ST_DONE] = doneFlag;
    statusValue[ST_MSG]  = msgFlag;
    statusValue[ST_PART] = partFlag;
    statusValue[ST_BUSY] = busy;
    statusValue[ST_SEED] = seedDone;
    statusValue[ST_RDY]  = rdyFlag;
  end
endmodule

// File: rtl/prng_datapath.sv
module prng_datapath
  import prng_pkg::*;
#(
  parameter int NW = NUM_WORDS,
  parameter int DW = WORD_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  prng_cmd_t     cmd,
  input  logic [AW-1:0] busAddr,
  input  logic [DW-1:0] busWdata,
  output logic [DW-1:0] outRdata,
  output logic          outHit
);
  localparam logic [AW-1:0] OUT_SPAN = AW'(4 * NW);

  logic [DW-1:0] seedWord [NW];
  logic [DW-1:0] stWord   [NW];
  logic [DW-1:0] outWord  [NW];
  logic [DW-1:0] tMix, nextTail;
  logic [AW-1:0] outOfs;

  assign tMix     = stWord[0] ^ (stWord[0] >> 2);
  assign nextTail = (stWord[NW-1] ^ (stWord[NW-1] << 4)) ^ (tMix ^ (tMix << 1));

  for (genvar g = 0; g < NW; g++) begin : gWord
    always_ff @(posedge clk) begin
      if (!rstN) seedWord[g] <= '0;
      else if (cmd.seedWe && cmd.seedSel == 3'(g)) seedWord[g] <= busWdata;
    end

    always_ff @(posedge clk) begin
      if (!rstN) outWord[g] <= '0;
      else if (cmd.step && cmd.wordSel == 3'(g)) outWord[g] <= nextTail;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stWord[g] <= '0;
      end else if (cmd.load) begin
        stWord[g] <= seedWord[g];
      end else if (cmd.step) begin
        if (g == NW - 1) stWord[g] <= nextTail;
        else             stWord[g] <= stWord[(g + 1) % NW];
      end
    end
  end

  assign outOfs = busAddr - OUT_BASE;
  assign outHit = (outOfs < OUT_SPAN) && (outOfs[1:0] == 2'b00);

  always_comb begin
    outRdata = '0;
    for (int i = 0; i < NW; i++) begin
      if (outHit && outOfs[2 +: 3] == 3'(i)) outRdata = outWord[i];
    end
  end
endmodule

// File: rtl/seeded_prng_periph.sv
module seeded_prng_periph
  import prng_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [WORD_W-1:0] busWdata,
  output logic [WORD_W-1:0] busRdata
);
  prng_cmd_t         cmd;
  logic [WORD_W-1:0] ctrlValue, statusValue, outRdata;
  logic              busy, ctrlHit, statHit, outHit;

  prng_ctrl #(.NW(NUM_WORDS), .DW(WORD_W), .AW(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .cmd(cmd), .ctrlValue(ctrlValue),
    .statusValue(statusValue), .busy(busy), .ctrlHit(ctrlHit),
    .statHit(statHit)
  );

  prng_datapath #(.NW(NUM_WORDS), .DW(WORD_W), .AW(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .busAddr(busAddr),
    .busWdata(busWdata), .outRdata(outRdata), .outHit(outHit)
  );

  always_comb begin
    if (ctrlHit)      busRdata = ctrlValue;
    else if (statHit) busRdata = statusValue;
    else if (outHit)  busRdata = outRdata;
    else              busRdata = '0;
  end
endmodule

// File: rtl/prng_periph_checker.sv
module prng_periph_checker
  import prng_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [WORD_W-1:0] busWdata,
  input logic [WORD_W-1:0] busRdata,
  input logic [WORD_W-1:0] ctrlValue,
  input logic [WORD_W-1:0] statusValue,
  input logic              busy
);
  logic isCtrl, isStat, isSeed, isOut, mapped;
  assign isCtrl = (busAddr == CTRL_OFS);
  assign isStat = (busAddr == STAT_OFS);
  assign isSeed = (busAddr >= SEED_BASE) && (busAddr < SEED_BASE + 9'(4 * NUM_WORDS))
                  && (busAddr[1:0] == 2'b00);
  assign isOut  = (busAddr >= OUT_BASE) && (busAddr < OUT_BASE + 9'(4 * NUM_WORDS))
                  && (busAddr[1:0] == 2'b00);
  assign mapped = isCtrl || isStat || isOut;

  assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    !mapped |-> busRdata == '0);

  assert_seed_done_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusValue[ST_SEED]) |-> $past(busWe && isSeed));

  assert_go_bit_cleared_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && isCtrl) |=> ctrlValue == ($past(busWdata) & ~(32'h1 << CTRL_GO_BIT)));

  assert_start_gated_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(busWe && isCtrl && busWdata[CTRL_ENG_BIT]
                          && busWdata[CTRL_GO_BIT] && statusValue[ST_SEED]));

  assert_done_on_finish_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> statusValue[ST_DONE]);

  assert_status_sw_bits_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && isStat) |=> statusValue[ST_MSG:ST_PART] == $past(busWdata[ST_MSG:ST_PART])
                          && statusValue[ST_SEED:ST_RDY] == $past(statusValue[ST_SEED:ST_RDY]));
endmodule

bind seeded_prng_periph prng_periph_checker u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
  .busWdata(busWdata), .busRdata(busRdata), .ctrlValue(ctrlValue),
  .statusValue(statusValue), .busy(busy)
);

// File: tb/tb_seeded_prng_periph.sv
module tb_seeded_prng_periph;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [8:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // behavioural model state
  logic [31:0] mCtrl;
  logic [31:0] mSeed [5];
  logic [31:0] mSt   [5];
  logic [31:0] mOut  [5];
  bit   [4:0]  mFlags;
  bit          mDone, mMsg, mPart;
  int          mBusy;

  seeded_prng_periph dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] modelRead(logic [8:0] a);
    logic [31:0] v = 32'h0;
    if (a == 9'h000) v = mCtrl;
    else if (a == 9'h010) begin
      v[5] = mDone; v[4] = mMsg; v[3] = mPart;
      v[2] = (mBusy != 0); v[1] = (mFlags == 5'h1f); v[0] = 1'b1;
    end else begin
      for (int k = 0; k < 5; k++) if (a == 9'h160 + 9'(4 * k)) v = mOut[k];
    end
    return v;
  endfunction

  task automatic modelReset();
    mCtrl = 0; mFlags = 0; mDone = 0; mMsg = 0; mPart = 0; mBusy = 0;
    for (int k = 0; k < 5; k++) begin mSeed[k] = 0; mSt[k] = 0; mOut[k] = 0; end
  endtask

  task automatic modelEdge(bit we, logic [8:0] a, logic [31:0] d);
    bit doneNow = 0;
    int preBusy = mBusy;
    logic [31:0] t, nv;
    if (mBusy > 0) begin
      t  = mSt[0] ^ (mSt[0] >> 2);
      nv = (mSt[4] ^ (mSt[4] << 4)) ^ (t ^ (t << 1));
      for (int k = 0; k < 4; k++) mSt[k] = mSt[k + 1];
      mSt[4] = nv;
      mOut[5 - mBusy] = nv;
      mBusy--;
      if (mBusy == 0) doneNow = 1;
    end
    if (we) begin
      if (a == 9'h000) begin
        mCtrl = d & ~32'h10;
        if (mFlags == 5'h1f && d[3] && d[4] && preBusy == 0) begin
          for (int k = 0; k < 5; k++) mSt[k] = mSeed[k];
          mBusy = 5;
        end
      end else if (a == 9'h010) begin
        mDone = d[5]; mMsg = d[4]; mPart = d[3];
      end else begin
        for (int k = 0; k < 5; k++)
          if (a == 9'h140 + 9'(4 * k)) begin mSeed[k] = d; mFlags[k] = 1'b1; end
      end
    end
    if (doneNow) mDone = 1;
  endtask

  // one bus cycle: drive at negedge, compare before the edge, update model at the edge
  task automatic op(bit we, logic [8:0] a, logic [31:0] d, string tag);
    logic [31:0] exp;
    busWe = we; busAddr = a; busWdata = d;
    #1;
    exp = modelRead(a);
    compared++;
    if (busRdata !== exp) begin
      mismatched++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, busRdata, exp);
    end
    @(posedge clk);
    modelEdge(we, a, d);
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(logic [8:0] a, string tag);
    op(1'b0, a, 32'h0, tag);
  endtask

  task automatic readAll(string tag);
    rd(9'h000, tag);
    rd(9'h010, tag);
    for (int k = 0; k < 5; k++) rd(9'h160 + 9'(4 * k), tag);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset values
    readAll("R1");

    // R2: unmapped and unaligned offsets, seed read, writes to results and holes
    rd(9'h004, "R2"); rd(9'h1fc, "R2"); rd(9'h162, "R2"); rd(9'h140, "R2");
    op(1'b1, 9'h160, 32'hdeadbeef, "R2");
    op(1'b1, 9'h008, 32'hffffffff, "R2");
    op(1'b1, 9'h174, 32'h12345678, "R2");
    readAll("R2");

    // R5 and R4: start request before seeds are complete
    op(1'b1, 9'h000, 32'hffff_ff18, "R5");
    rd(9'h000, "R4"); rd(9'h010, "R5");

    // R3: seed flags, including a repeated write
    op(1'b1, 9'h140, 32'h1234_5678, "R3");
    op(1'b1, 9'h144, 32'h9abc_def0, "R3");
    op(1'b1, 9'h148, 32'h0f0f_0f0f, "R3");
    op(1'b1, 9'h148, 32'hcafe_f00d, "R3");
    op(1'b1, 9'h14c, 32'h8000_0001, "R3");
    rd(9'h010, "R3");
    op(1'b1, 9'h150, 32'h7654_3210, "R3");
    rd(9'h010, "R3");

    // R5: go without engine select, then engine select without go
    op(1'b1, 9'h000, 32'h0000_0010, "R5");
    rd(9'h010, "R5");
    op(1'b1, 9'h000, 32'h0000_0008, "R5");
    rd(9'h010, "R5");

    // R6, R7: accepted run, observe every cycle of it
    op(1'b1, 9'h000, 32'h0000_0018, "R6");
    for (int i = 0; i < 6; i++) rd(9'h010, "R6");
    readAll("R7");

    // R8: status write of all ones, then zeros
    op(1'b1, 9'h010, 32'hffff_ffff, "R8");
    rd(9'h010, "R8");
    op(1'b1, 9'h010, 32'h0000_0000, "R8");
    rd(9'h010, "R8");

    // R10: new start request during a run, with a changed seed
    op(1'b1, 9'h144, 32'h0bad_c0de, "R10");
    op(1'b1, 9'h000, 32'h0000_0018, "R10");
    rd(9'h160, "R10");
    op(1'b1, 9'h000, 32'h0000_00f8, "R10");
    rd(9'h000, "R10");
    for (int i = 0; i < 3; i++) rd(9'h010, "R10");
    readAll("R10");

    // R9: status write clearing everything on the finishing edge
    op(1'b1, 9'h000, 32'h0000_0018, "R9");
    for (int i = 0; i < 4; i++) rd(9'h010, "R9");
    op(1'b1, 9'h010, 32'h0000_0000, "R9");
    rd(9'h010, "R9");
    readAll("R9");

    // R3: seed flags survive runs; only reset clears them
    rstN = 1'b0;
    @(posedge clk); modelReset(); @(negedge clk);
    rstN = 1'b1;
    readAll("R1");
    op(1'b1, 9'h000, 32'h0000_0018, "R3");
    rd(9'h010, "R3");

    finished = 1;
    summary();
    $finish;
  end
endmodule